// File: doc/BRIEF.md
# Interrupt Distributor

This block is the shared front end of a small multi-processor interrupt controller. It collects level-sensitive peripheral interrupt lines and software-raised interrupts, and it keeps the per-interrupt enable, priority, CPU target and trigger configuration state in a 32-bit memory-mapped register bank. For every CPU interface it presents one candidate: the most urgent interrupt that is pending for that CPU, enabled, and steered to it.

Software programs the bank with single-word reads and writes. IDs 0 to 15 are software-generated and pending per CPU. IDs 16 to 31 are reserved and never become pending. IDs 32 and up are shared peripheral lines. Each CPU interface acknowledges a software interrupt through its own acknowledge strobe and ID. Peripheral lines are level-sensitive, so they stay pending for as long as the line is held high.

Top module: `intc_distributor`

## Requirements
- R1: The enable-set words at 0x100 + (n/32)*4 and the enable-clear words at 0x180 + (n/32)*4 act on interrupt n through bit n%32. A 1 bit written to a set word sets the enable and a 1 bit written to a clear word clears it. A 0 bit leaves the enable unchanged. Both words read back the current enables.
- R2: The priority of interrupt n is the byte at 0x400 + (n/4)*4, bits [8*(n%4)+7 : 8*(n%4)]. Its target mask is the byte at the same position from 0x800. Bit c of the target byte steers a peripheral interrupt to CPU c. Both arrays read back what was written.
- R3: The trigger configuration is 2 bits per interrupt, 16 interrupts per word, starting at 0xC00 (interrupt n in bits [2*(n%16)+1 : 2*(n%16)]). It reads back what was written. Every value gives level-sensitive behaviour and leaves forwarding unchanged.
- R4: Bit 0 at 0x000 is the global enable. While it is 0, cpu_irq is 0 for every CPU.
- R5: The word at 0x004 is read-only. Bits [4:0] read NUM_IRQ/32-1, bits [7:5] read NUM_CPU-1 and all other bits read 0.
- R6: A write to 0xF00 makes ID wdata[3:0] pending for every CPU c whose bit wdata[16+c] is 1. A software interrupt reaches only the CPUs it was raised for, whatever its target byte holds.
- R7: irq_lines[k] is interrupt 32+k. It is sampled on every clock edge and is pending while it is sampled high, which means it drops one cycle after the line falls. It is offered only to CPUs whose bit is set in its target byte.
- R8: When the global enable is set and at least one enabled pending interrupt is eligible for CPU c, cpu_irq[c] is 1. cpu_irq_id and cpu_irq_prio for that CPU then give the candidate with the lowest priority value, and a tie goes to the lower ID. With no candidate the ID reads 1023 and the priority reads 0xFF.
- R9: A pulse on cpu_ack_vld[c] with an ID below 16 clears that software interrupt for CPU c only. An acknowledge carrying a peripheral ID has no effect.
- R10: After reset, every enable, priority, target, configuration bit, the global enable and bus_rdata are 0. Unimplemented offsets and 0xF00 read 0, and writes to unimplemented offsets change nothing.
- R11: bus_rdata takes the addressed word on the clock edge where bus_rd is sampled high, and it holds its value at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | NUM_IRQ-32 | Level peripheral lines, bit k is ID 32+k |
| cpu_ack_vld | input | NUM_CPU | Per-CPU acknowledge strobe |
| cpu_ack_id | input | NUM_CPU*10 | Per-CPU acknowledged ID, CPU c in bits [10c+9:10c] |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt request |
| cpu_irq_id | output | NUM_CPU*10 | Per-CPU selected ID, CPU c in bits [10c+9:10c] |
| cpu_irq_prio | output | NUM_CPU*8 | Per-CPU selected priority, CPU c in bits [8c+7:8c] |

## Verification
The hardest case to reach is a CPU that holds several live candidates at once, so that both the priority comparison and the lower-ID tie rule decide the result. The stimulus builds this up on purpose. Two peripheral lines are steered to overlapping CPU sets, and the bench then rewrites one priority byte so that it equals the other. Software interrupts with equal priority are also raised on one CPU and then acknowledged one at a time, which shows that the next candidate takes over and that the other CPUs are left untouched.

// File: rtl/intc_dist_pkg.sv
package intc_dist_pkg;
  localparam int unsigned ID_W     = 10;
  localparam int unsigned SGI_N    = 16;
  localparam int unsigned SPI_BASE = 32;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_TYPE  = 12'h004;
  localparam logic [11:0] OFS_ENSET = 12'h100;
  localparam logic [11:0] OFS_ENCLR = 12'h180;
  localparam logic [11:0] OFS_PRIO  = 12'h400;
  localparam logic [11:0] OFS_TGT   = 12'h800;
  localparam logic [11:0] OFS_CFG   = 12'hC00;
  localparam logic [11:0] OFS_SGI   = 12'hF00;

  typedef logic [7:0] prio_t;
endpackage

// File: rtl/intc_dist_regs.sv
module intc_dist_regs
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [11:0]                addr,
  input  logic [31:0]                wdata,
  input  logic                       wr,
  input  logic                       rd,
  output logic [31:0]                rdata,
  output logic                       glob_en,
  output logic [NUM_IRQ-1:0]         en,
  output logic [NUM_IRQ-1:0][7:0]    prio,
  output logic [NUM_IRQ-1:0][7:0]    tgt,
  output logic                       sgi_fire,
  output logic [NUM_CPU-1:0]         sgi_cpus,
  output logic [3:0]                 sgi_id
);
  localparam int unsigned NW32 = NUM_IRQ / 32;
  localparam int unsigned NW4  = NUM_IRQ / 4;
  localparam int unsigned NW16 = NUM_IRQ / 16;

  logic                    ctrl_q, ctrl_d;
  logic [NUM_IRQ-1:0]      en_q, en_d;
  logic [NUM_IRQ-1:0][7:0] prio_q, prio_d;
  logic [NUM_IRQ-1:0][7:0] tgt_q, tgt_d;
  logic [NUM_IRQ-1:0][1:0] cfg_q, cfg_d;
  logic [31:0]             rdata_q, rdata_d;

  // write decode
  always_comb begin
    ctrl_d = ctrl_q;
    en_d   = en_q;
    prio_d = prio_q;
    tgt_d  = tgt_q;
    cfg_d  = cfg_q;
    if (addr == OFS_CTRL) ctrl_d = wdata[0];
    for (int w = 0; w < NW32; w++) begin
      if (addr == OFS_ENSET + 12'(4 * w)) en_d[w*32 +: 32] = en_q[w*32 +: 32] | wdata;
      if (addr == OFS_ENCLR + 12'(4 * w)) en_d[w*32 +: 32] = en_q[w*32 +: 32] & ~wdata;
    end
    for (int w = 0; w < NW4; w++) begin
      for (int k = 0; k < 4; k++) begin
        if (addr == OFS_PRIO + 12'(4 * w)) prio_d[4*w+k] = wdata[8*k +: 8];
        if (addr == OFS_TGT  + 12'(4 * w)) tgt_d[4*w+k]  = wdata[8*k +: 8];
      end
    end
    for (int w = 0; w < NW16; w++) begin
      for (int k = 0; k < 16; k++) begin
        if (addr == OFS_CFG + 12'(4 * w)) cfg_d[16*w+k] = wdata[2*k +: 2];
      end
    end
  end

  // read decode
  always_comb begin
    rdata_d = '0;
    if (addr == OFS_CTRL) rdata_d[0] = ctrl_q;
    if (addr == OFS_TYPE) begin
      rdata_d[4:0] = 5'(NW32 - 1);
      rdata_d[7:5] = 3'(NUM_CPU - 1);
    end
    for (int w = 0; w < NW32; w++) begin
      if (addr == OFS_ENSET + 12'(4 * w) || addr == OFS_ENCLR + 12'(4 * w))
        rdata_d = en_q[w*32 +: 32];
    end
    for (int w = 0; w < NW4; w++) begin
      for (int k = 0; k < 4; k++) begin
        if (addr == OFS_PRIO + 12'(4 * w)) rdata_d[8*k +: 8] = prio_q[4*w+k];
        if (addr == OFS_TGT  + 12'(4 * w)) rdata_d[8*k +: 8] = tgt_q[4*w+k];
      end
    end
    for (int w = 0; w < NW16; w++) begin
      for (int k = 0; k < 16; k++) begin
        if (addr == OFS_CFG + 12'(4 * w)) rdata_d[2*k +: 2] = cfg_q[16*w+k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      en_q   <= '0;
      prio_q <= '0;
      tgt_q  <= '0;
      cfg_q  <= '0;
    end else if (wr) begin
      ctrl_q <= ctrl_d;
      en_q   <= en_d;
      prio_q <= prio_d;
      tgt_q  <= tgt_d;
      cfg_q  <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata    = rdata_q;
  assign glob_en  = ctrl_q;
  assign en       = en_q;
  assign prio     = prio_q;
  assign tgt      = tgt_q;
  assign sgi_fire = wr && (addr == OFS_SGI);
  assign sgi_cpus = wdata[16 +: NUM_CPU];
  assign sgi_id   = wdata[3:0];
endmodule

// File: rtl/intc_dist_pending.sv
module intc_dist_pending
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_IRQ-SPI_BASE-1:0]         spi_in,
  input  logic                                sgi_fire,
  input  logic [NUM_CPU-1:0]                  sgi_cpus,
  input  logic [3:0]                          sgi_id,
  input  logic [NUM_CPU-1:0]                  ack_vld,
  input  logic [NUM_CPU-1:0][ID_W-1:0]        ack_id,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0]     pend
);
  localparam int unsigned NUM_SPI = NUM_IRQ - SPI_BASE;

  logic [NUM_SPI-1:0]            spi_q;
  logic [NUM_CPU-1:0][SGI_N-1:0] sgi_q, sgi_d;

  always_comb begin
    sgi_d = sgi_q;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (ack_vld[c] && ack_id[c] < 10'd16) sgi_d[c][ack_id[c][3:0]] = 1'b0;
      if (sgi_fire && sgi_cpus[c])         sgi_d[c][sgi_id]         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_q <= '0;
      sgi_q <= '0;
    end else begin
      spi_q <= spi_in;
      sgi_q <= sgi_d;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_pend
    assign pend[c] = {spi_q, {(SPI_BASE-SGI_N){1'b0}}, sgi_q[c]};
  end
endmodule

// File: rtl/intc_dist_arbiter.sv
module intc_dist_arbiter
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0]      cand,
  input  logic [NUM_IRQ-1:0][7:0] prio,
  output logic                    req,
  output logic [ID_W-1:0]         id,
  output prio_t                   pri
);
  always_comb begin
    req = 1'b0;
    id  = ID_NONE;
    pri = 8'hFF;
    // ascending scan with strict compare: equal priority keeps the lower ID
    for (int n = 0; n < NUM_IRQ; n++) begin
      if (cand[n] && (!req || prio[n] < pri)) begin
        req = 1'b1;
        id  = ID_W'(n);
        pri = prio[n];
      end
    end
  end
endmodule

// File: rtl/intc_distributor.sv
module intc_distributor
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [11:0]                 bus_addr,
  input  logic [31:0]                 bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_IRQ-33:0]         irq_lines,
  input  logic [NUM_CPU-1:0]          cpu_ack_vld,
  input  logic [NUM_CPU*10-1:0]       cpu_ack_id,
  output logic [NUM_CPU-1:0]          cpu_irq,
  output logic [NUM_CPU*10-1:0]       cpu_irq_id,
  output logic [NUM_CPU*8-1:0]        cpu_irq_prio
);
  logic [1:0]                     rst_sync_q;
  logic                           rst_int_n;
  logic                           glob_en;
  logic [NUM_IRQ-1:0]             en;
  logic [NUM_IRQ-1:0][7:0]        prio;
  logic [NUM_IRQ-1:0][7:0]        tgt;
  logic                           sgi_fire;
  logic [NUM_CPU-1:0]             sgi_cpus;
  logic [3:0]                     sgi_id;
  logic [NUM_CPU-1:0][ID_W-1:0]   ack_id_a;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] pend_a;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  intc_dist_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .rdata(bus_rdata), .glob_en(glob_en),
    .en(en), .prio(prio), .tgt(tgt), .sgi_fire(sgi_fire),
    .sgi_cpus(sgi_cpus), .sgi_id(sgi_id)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_ack
    assign ack_id_a[c] = cpu_ack_id[c*10 +: 10];
  end

  intc_dist_pending #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_pend (
    .clk(clk), .rst_n(rst_int_n), .spi_in(irq_lines), .sgi_fire(sgi_fire),
    .sgi_cpus(sgi_cpus), .sgi_id(sgi_id), .ack_vld(cpu_ack_vld),
    .ack_id(ack_id_a), .pend(pend_a)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] cand;
    logic               req;
    logic [ID_W-1:0]    id;
    prio_t              pri;

    always_comb begin
      for (int n = 0; n < NUM_IRQ; n++) begin
        // software IDs are already per CPU; only shared lines use the target byte
        cand[n] = glob_en && en[n] && pend_a[c][n] && (n < SPI_BASE || tgt[n][c]);
      end
    end

    intc_dist_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
      .cand(cand), .prio(prio), .req(req), .id(id), .pri(pri)
    );

    assign cpu_irq[c]             = req;
    assign cpu_irq_id[c*10 +: 10] = id;
    assign cpu_irq_prio[c*8 +: 8] = pri;
  end
endmodule

// File: rtl/intc_dist_chk.sv
module intc_dist_chk
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [11:0]           bus_addr,
  input logic [31:0]           bus_wdata,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [31:0]           bus_rdata,
  input logic                  glob_en,
  input logic [NUM_IRQ-1:0]    en,
  input logic [NUM_IRQ-33:0]   irq_lines,
  input logic [NUM_IRQ-1:0]    pend0,
  input logic [NUM_CPU-1:0]    cpu_irq,
  input logic [NUM_CPU*10-1:0] cpu_irq_id,
  input logic [NUM_CPU*8-1:0]  cpu_irq_prio
);
  a_r4_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> cpu_irq == '0);

  a_r1_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENSET && bus_wdata[0]) |=> en[0]);

  a_r1_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENCLR && bus_wdata[0]) |=> !en[0]);

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r7_line_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend0[SPI_BASE] == $past(irq_lines[0]));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    logic en_at;
    assign en_at = |(en & ({{(NUM_IRQ-1){1'b0}}, 1'b1} << cpu_irq_id[c*10 +: 10]));

    a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq[c] |-> (cpu_irq_id[c*10 +: 10] == ID_NONE && cpu_irq_prio[c*8 +: 8] == 8'hFF));

    a_r8_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> (en_at && glob_en));
  end
endmodule

bind intc_distributor intc_dist_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .glob_en(glob_en),
  .en(en), .irq_lines(irq_lines), .pend0(pend_a[0]), .cpu_irq(cpu_irq),
  .cpu_irq_id(cpu_irq_id), .cpu_irq_prio(cpu_irq_prio)
);

// File: tb/test_intc_distributor.sv
module test_intc_distributor;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ = 64;
  localparam int NUM_CPU = 8;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [11:0]             bus_addr;
  logic [31:0]             bus_wdata;
  logic                    bus_wr, bus_rd;
  logic [31:0]             bus_rdata;
  logic [NUM_IRQ-33:0]     irq_lines;
  logic [NUM_CPU-1:0]      cpu_ack_vld;
  logic [NUM_CPU*10-1:0]   cpu_ack_id;
  logic [NUM_CPU-1:0]      cpu_irq;
  logic [NUM_CPU*10-1:0]   cpu_irq_id;
  logic [NUM_CPU*8-1:0]    cpu_irq_prio;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       req_q[$];
  logic        rd_lat = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_distributor #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) i_intc_distributor (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .cpu_ack_vld(cpu_ack_vld), .cpu_ack_id(cpu_ack_id),
    .cpu_irq(cpu_irq), .cpu_irq_id(cpu_irq_id), .cpu_irq_prio(cpu_irq_prio)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: read data appears after the edge that sampled bus_rd
  always @(posedge clk) rd_lat <= bus_rd;
  always @(negedge clk) begin
    if (rd_lat) begin
      if (exp_q.size() == 0) chk("R11 unexpected read", 32'd1, 32'd0);
      else chk(req_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ack(int c, logic [9:0] id);
    @(negedge clk); cpu_ack_vld[c] = 1'b1; cpu_ack_id[c*10 +: 10] = id;
    @(negedge clk); cpu_ack_vld = '0;
  endtask

  task automatic cpu(int c, logic r, logic [9:0] id, logic [7:0] p, string req);
    chk({req, " irq"},  {31'd0, cpu_irq[c]}, {31'd0, r});
    chk({req, " id"},   {22'd0, cpu_irq_id[c*10 +: 10]}, {22'd0, id});
    chk({req, " prio"}, {24'd0, cpu_irq_prio[c*8 +: 8]}, {24'd0, p});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    irq_lines = '0; cpu_ack_vld = '0; cpu_ack_id = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 cpu_irq", {24'd0, cpu_irq}, 32'd0);
    chk("R10 rdata", bus_rdata, 32'd0);
    cpu(0, 1'b0, 10'd1023, 8'hFF, "R8 idle");
    rd(12'h000, 32'd0, "R10 ctrl");
    rd(12'h100, 32'd0, "R10 enable");
    rd(12'h420, 32'd0, "R10 prio");
    rd(12'h004, 32'h0000_00E1, "R5 type");

    // R1 set/clear
    wr(12'h100, 32'h5);
    wr(12'h104, 32'h8000_0003);
    rd(12'h100, 32'h5, "R1 set read");
    rd(12'h180, 32'h5, "R1 clear-word read");
    wr(12'h180, 32'h4);
    rd(12'h100, 32'h1, "R1 clear");
    wr(12'h100, 32'h0);
    rd(12'h180, 32'h1, "R1 zero bits");
    rd(12'h184, 32'h8000_0003, "R1 upper word");

    // R2 priority and target lanes
    wr(12'h420, 32'h4433_2211);
    wr(12'h43C, 32'h1000_0000);
    wr(12'h820, 32'h0000_0201);
    wr(12'h83C, 32'h0300_0000);
    rd(12'h420, 32'h4433_2211, "R2 prio 32");
    rd(12'h43C, 32'h1000_0000, "R2 prio 63");
    rd(12'h820, 32'h0000_0201, "R2 tgt 32");
    rd(12'h83C, 32'h0300_0000, "R2 tgt 63");

    // R3 config readback
    wr(12'hC08, 32'hAAAA_AAAA);
    rd(12'hC08, 32'hAAAA_AAAA, "R3 cfg");

    // R4 global enable off
    irq_lines[0] = 1'b1;
    repeat (2) @(negedge clk);
    cpu(0, 1'b0, 10'd1023, 8'hFF, "R4 off");
    wr(12'h000, 32'h1);
    rd(12'h000, 32'h1, "R4 ctrl read");
    cpu(0, 1'b1, 10'd32, 8'h11, "R7 line 32 cfg R3");
    cpu(1, 1'b0, 10'd1023, 8'hFF, "R7 not targeted");

    // R8 priority ordering and tie break
    irq_lines[31] = 1'b1;
    repeat (2) @(negedge clk);
    cpu(0, 1'b1, 10'd63, 8'h10, "R8 lower value wins");
    cpu(1, 1'b1, 10'd63, 8'h10, "R7 multi-target");
    cpu(2, 1'b0, 10'd1023, 8'hFF, "R7 cpu2 none");
    wr(12'h420, 32'h4433_2210);
    cpu(0, 1'b1, 10'd32, 8'h10, "R8 tie lower id");

    // R7 level drop after one edge
    irq_lines[0] = 1'b0;
    @(negedge clk);
    cpu(0, 1'b1, 10'd63, 8'h10, "R7 level drop");
    wr(12'h184, 32'h8000_0000);
    cpu(0, 1'b0, 10'd1023, 8'hFF, "R1 disable 63");
    cpu(1, 1'b0, 10'd1023, 8'hFF, "R1 disable 63 cpu1");

    // R6 software interrupts
    wr(12'hF00, 32'h000C_0000);
    cpu(2, 1'b1, 10'd0, 8'h00, "R6 sgi cpu2");
    cpu(3, 1'b1, 10'd0, 8'h00, "R6 sgi cpu3");
    cpu(0, 1'b0, 10'd1023, 8'hFF, "R6 sgi not cpu0");
    wr(12'hF00, 32'h0004_0002);
    cpu(2, 1'b1, 10'd0, 8'h00, "R6 disabled sgi");
    wr(12'h100, 32'h4);
    cpu(2, 1'b1, 10'd0, 8'h00, "R8 sgi tie");

    // R9 acknowledge
    ack(2, 10'd0);
    cpu(2, 1'b1, 10'd2, 8'h00, "R9 ack next");
    cpu(3, 1'b1, 10'd0, 8'h00, "R9 other cpu kept");
    ack(2, 10'd2);
    cpu(2, 1'b0, 10'd1023, 8'hFF, "R9 ack last");
    irq_lines[0] = 1'b1;
    @(negedge clk);
    ack(0, 10'd32);
    cpu(0, 1'b1, 10'd32, 8'h10, "R9 spi ack ignored");

    // R10 unimplemented offsets
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, 32'd0, "R10 unimplemented");
    rd(12'hF00, 32'd0, "R10 sgi read");
    rd(12'h000, 32'h1, "R10 ctrl untouched");

    // R11 read data hold
    rd(12'h420, 32'h4433_2210, "R11 read");
    wr(12'h420, 32'h0);
    repeat (2) @(negedge clk);
    chk("R11 hold", bus_rdata, 32'h4433_2210);
    rd(12'h420, 32'h0, "R11 update");

    // R4 disable drops every CPU
    wr(12'h000, 32'h0);
    chk("R4 all off", {24'd0, cpu_irq}, 32'd0);
    cpu(3, 1'b0, 10'd1023, 8'hFF, "R4 cpu3 off");

    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule